// File: doc/BRIEF.md
# SPI Receive Flag and Overflow Controller

This block sits between the receive shifter of a serial peripheral interface and a CPU register bus. Each time the shifter finishes a byte it pulses a completion strobe carrying that byte. The block holds one received byte in a data register and keeps two status flags, "receive full" and "overflow". A byte that arrives while the previous one is still unread is thrown away and raises overflow. Overflow is sticky: it stays set, and while it is set every later byte is also thrown away, even after receive full has been cleared.

Software clears a flag by reading the status register and then reading the data register. The status read records, or arms, exactly the flags it saw set. The data read that follows clears only the armed flags. A status read that returned a flag clear therefore cannot lead to that flag being cleared, even if the flag is set in the meantime. Two interrupt requests are produced: one from receive full, and one from overflow that reaches the CPU only when the error enable is set.

The byte input is a strobe with no back-pressure, because the shifter cannot be stalled. Every strobed byte is consumed in its cycle, either captured or discarded. The read port has no wait states, and its data is valid in the same cycle as the read strobe.

Top module: `spi_rx_flagctl`

## Requirements
- R1: After reset both flags, both arm indications and the data register are zero, and both interrupt requests are low.
- R2: A strobed byte that arrives while receive full and overflow are both clear sets receive full, and the byte appears in the data register on the next cycle.
- R3: A strobed byte that arrives while receive full is set (and no clearing data read happens in that cycle) sets overflow and is discarded, so the data register keeps its value.
- R4: While overflow is set, each strobed byte is discarded: receive full does not become set and the data register does not change.
- R5: A status read that sees receive full set, followed later by a data read with no other status read between them, clears receive full.
- R6: A data read clears overflow only when overflow was already set at the preceding status read. Otherwise overflow stays set, even if the same data read clears receive full.
- R7: A data read clears no flag unless a status read armed that flag, and each data read uses up the arming. A status read that saw a flag clear does not arm it.
- R8: A status read (rd_addr = 0) returns receive full in bit DATA_W-1 and overflow in bit DATA_W-2, with all other bits zero. rd_data is zero when rd_en is low.
- R9: irq_rx is high exactly when receive full is set and rx_ie is high. irq_err is high exactly when overflow is set and err_ie is high.
- R10: When a byte arrives in the same cycle as a data read that clears receive full, the clear is applied first. The new byte is then captured and sets receive full.
- R11: A data read (rd_addr = 1) returns the held byte. After a byte is discarded, the earlier unread byte can be read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe: a received byte is complete |
| byte_data | input | DATA_W | Received byte, valid with byte_valid |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Read select: 0 status, 1 data |
| rd_data | output | DATA_W | Read data, combinational, same cycle as rd_en |
| rx_ie | input | 1 | Receive full interrupt enable |
| err_ie | input | 1 | Overflow (error) interrupt enable |
| irq_rx | output | 1 | Receive full interrupt request |
| irq_err | output | 1 | Overflow interrupt request |

## Verification
Some properties can be checked on every cycle. The assertions do this for the capture of a byte into an empty register, the discard of bytes and the hold of the data register while full or overflow is set, flags staying set when no data read occurs, the zero bits of the status word, and interrupt gating. Other behaviour depends on the order of reads spread over several cycles. This covers clearing only armed flags, an unarmed status read failing to clear a flag set after it, the missed-overflow sequence, and a byte colliding with a clearing read. The bench's scenarios show these, together with a random run compared against a behavioural model on every cycle.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  // number of status flags handled by the controller
  localparam int NFLG = 2;
  // flag indices inside the flag vector
  localparam int FLG_OVF  = 0;
  localparam int FLG_FULL = 1;
  // read select encoding
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_DATA   = 1'b1;
endpackage

// File: rtl/rxs_arm_track.sv
module rxs_arm_track
  import spi_rx_pkg::*;
#(
  parameter int N = NFLG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stat_rd,
  input  logic         data_rd,
  input  logic [N-1:0] flags,
  output logic [N-1:0] clr
);
  logic [N-1:0] arm_q;

  for (genvar i = 0; i < N; i++) begin : g_arm
    // a status read samples what it returned; a data read consumes it
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       arm_q[i] <= 1'b0;
      else if (stat_rd) arm_q[i] <= flags[i];
      else if (data_rd) arm_q[i] <= 1'b0;
    end
    assign clr[i] = data_rd & arm_q[i];
  end
endmodule

// File: rtl/rxs_flag_core.sv
module rxs_flag_core
  import spi_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_valid,
  input  logic [NFLG-1:0] clr,
  output logic [NFLG-1:0] flags,
  output logic            accept
);
  logic full_q, ovf_q;
  logic full_after_clr, ovf_after_clr;

  // clears take effect before the incoming byte is judged
  always_comb begin
    full_after_clr = full_q & ~clr[FLG_FULL];
    ovf_after_clr  = ovf_q  & ~clr[FLG_OVF];
    accept         = byte_valid & ~full_after_clr & ~ovf_after_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      full_q <= full_after_clr | accept;
      ovf_q  <= ovf_after_clr | (byte_valid & full_after_clr);
    end
  end

  always_comb begin
    flags           = '0;
    flags[FLG_FULL] = full_q;
    flags[FLG_OVF]  = ovf_q;
  end
endmodule

// File: rtl/rxs_data_hold.sv
module rxs_data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/spi_rx_flagctl.sv
module spi_rx_flagctl
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_ie,
  input  logic              err_ie,
  output logic              irq_rx,
  output logic              irq_err
);
  localparam int PAD_W = DATA_W - NFLG;

  logic              stat_rd, data_rd, accept;
  logic [NFLG-1:0]   clr, flag_q;
  logic              full_q, ovf_q;
  logic [DATA_W-1:0] hold_q;

  assign stat_rd = rd_en & (rd_addr == SEL_STATUS);
  assign data_rd = rd_en & (rd_addr == SEL_DATA);

  rxs_arm_track #(.N(NFLG)) u_arm (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
    .flags(flag_q), .clr(clr)
  );

  rxs_flag_core u_flags (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .clr(clr),
    .flags(flag_q), .accept(accept)
  );

  rxs_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(byte_data), .dout(hold_q)
  );

  assign full_q = flag_q[FLG_FULL];
  assign ovf_q  = flag_q[FLG_OVF];

  always_comb begin
    rd_data = '0;
    if (data_rd)      rd_data = hold_q;
    else if (stat_rd) rd_data = {full_q, ovf_q, {PAD_W{1'b0}}};
  end

  assign irq_rx  = full_q & rx_ie;
  assign irq_err = ovf_q & err_ie;
endmodule

// File: rtl/spi_rx_flagctl_chk.sv
module spi_rx_flagctl_chk
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid,
  input logic [DATA_W-1:0] byte_data,
  input logic              rd_en,
  input logic              rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_ie,
  input logic              err_ie,
  input logic              irq_rx,
  input logic              irq_err,
  input logic              full_q,
  input logic              ovf_q,
  input logic [DATA_W-1:0] hold_q
);
  logic drd;
  assign drd = rd_en && (rd_addr == SEL_DATA);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !full_q && !ovf_q |=> full_q && (hold_q == $past(byte_data)));

  assert_overflow_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && full_q && !ovf_q && !drd |=> ovf_q && $stable(hold_q));

  assert_discard_while_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && ovf_q && !drd |=> ovf_q && $stable(hold_q) && $stable(full_q));

  assert_full_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !drd |=> full_q);

  assert_ovf_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !drd |=> ovf_q);

  assert_status_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (rd_addr == SEL_STATUS) |-> rd_data[DATA_W-3:0] == '0);

  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  assert_err_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> err_ie && ovf_q);

  assert_rx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_ie && full_q);
endmodule

bind spi_rx_flagctl spi_rx_flagctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rx_ie(rx_ie),
  .err_ie(err_ie), .irq_rx(irq_rx), .irq_err(irq_err),
  .full_q(full_q), .ovf_q(ovf_q), .hold_q(hold_q)
);

// File: tb/test_spi_rx_flagctl.sv
module test_spi_rx_flagctl;
  localparam int DATA_W = 8;
  localparam int CLK_PERIOD = 10;
  localparam logic ST = 1'b0;
  localparam logic DT = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0;
  logic [DATA_W-1:0] byte_data = '0;
  logic rd_en = 1'b0;
  logic rd_addr = 1'b0;
  logic rx_ie = 1'b0;
  logic err_ie = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic irq_rx, irq_err;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  bit m_full, m_ovf, m_arm_f, m_arm_o;
  int m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rx_flagctl #(.DATA_W(DATA_W)) i_spi_rx_flagctl (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rx_ie(rx_ie),
    .err_ie(err_ie), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_read(input bit re, input bit ra);
    if (!re) return 0;
    if (ra == DT) return m_data;
    return (int'(m_full) << 7) | (int'(m_ovf) << 6);
  endfunction

  task automatic compare_all();
    int exp_rd;
    exp_rd = model_read(rd_en, rd_addr);
    check(irq_rx == (m_full && rx_ie), "R9 irq_rx", irq_rx, m_full && rx_ie);
    check(irq_err == (m_ovf && err_ie), "R9 irq_err", irq_err, m_ovf && err_ie);
    if (rd_en && rd_addr == DT) check(int'(rd_data) == exp_rd, "R11 data read", rd_data, exp_rd);
    else check(int'(rd_data) == exp_rd, "R8 status/idle read", rd_data, exp_rd);
  endtask

  task automatic model_update(input bit v, input int b, input bit re, input bit ra);
    bit cf, co, f, o;
    cf = re && ra == DT && m_arm_f;
    co = re && ra == DT && m_arm_o;
    if (re && ra == ST) begin m_arm_f = m_full; m_arm_o = m_ovf; end
    else if (re && ra == DT) begin m_arm_f = 0; m_arm_o = 0; end
    f = m_full && !cf;
    o = m_ovf && !co;
    if (v) begin
      if (o) ;
      else if (f) o = 1;
      else begin f = 1; m_data = b; end
    end
    m_full = f;
    m_ovf = o;
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic step(input bit v, input int b, input bit re, input bit ra,
                      input bit chk, input int exp, input string tag);
    byte_valid = v;
    byte_data = b[DATA_W-1:0];
    rd_en = re;
    rd_addr = ra;
    #1;
    compare_all();
    if (chk) check(int'(rd_data) == exp, tag, rd_data, exp);
    @(posedge clk);
    model_update(v, b, re, ra);
    @(negedge clk);
  endtask

  task automatic rx(input int b);          step(1, b, 0, ST, 0, 0, ""); endtask
  task automatic srd(input int e, input string t); step(0, 0, 1, ST, 1, e, t); endtask
  task automatic drd(input int e, input string t); step(0, 0, 1, DT, 1, e, t); endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    m_full = 0; m_ovf = 0; m_arm_f = 0; m_arm_o = 0; m_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(irq_rx == 0 && irq_err == 0, "R1 irqs after reset", {irq_rx, irq_err}, 0);
    srd(8'h00, "R1 status after reset");
    drd(8'h00, "R1 data after reset");
    rx_ie = 1'b1;
    // R2/R5 plain receive and clear
    rx(8'h11);
    srd(8'h80, "R2 full set");
    drd(8'h11, "R2 byte captured");
    srd(8'h00, "R5 full cleared");
    // missed overflow sequence: R3 R4 R6 R11
    rx(8'h22);
    srd(8'h80, "R5 arm full");
    rx(8'h33);
    drd(8'h22, "R11 earlier byte kept");
    srd(8'h40, "R6 overflow not cleared when unarmed");
    rx(8'h44);
    srd(8'h40, "R4 byte blocked by overflow");
    drd(8'h22, "R11 earlier byte read again");
    srd(8'h00, "R6 overflow cleared after armed read");
    // R7 unarmed data read, and status read that saw flag clear
    rx(8'h55);
    drd(8'h55, "R7 data read unarmed");
    srd(8'h80, "R7 full survives unarmed read");
    drd(8'h55, "R7 armed data read");
    srd(8'h00, "R7 cleared, this read arms nothing");
    rx(8'h66);
    drd(8'h66, "R7 data read after clear-seeing status");
    srd(8'h80, "R7 full not cleared by stale arm");
    drd(8'h66, "R7 clear");
    // R10 byte in same cycle as clearing data read
    rx(8'h77);
    srd(8'h80, "R10 arm");
    step(1, 8'h88, 1, DT, 1, 8'h77, "R10 read old byte");
    srd(8'h80, "R10 new byte sets full");
    drd(8'h88, "R10 new byte captured");
    srd(8'h00, "R10 cleared");
    // R3 and R9 interrupt gating
    err_ie = 1'b0;
    rx(8'h99);
    rx(8'haa);
    check(irq_err == 0, "R9 irq_err masked", irq_err, 0);
    err_ie = 1'b1;
    #1;
    check(irq_err == 1, "R9 irq_err enabled", irq_err, 1);
    rx_ie = 1'b0;
    #1;
    check(irq_rx == 0, "R9 irq_rx masked", irq_rx, 0);
    srd(8'hc0, "R3 full and overflow");
    drd(8'h99, "R3 discarded byte not stored");
    srd(8'h00, "R6 both cleared");
    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      if ($urandom % 16 == 0) rx_ie = $urandom % 2;
      if ($urandom % 16 == 0) err_ie = $urandom % 2;
      step(($urandom % 3) == 0, $urandom % 256, $urandom % 2, $urandom % 2, 0, 0, "");
    end
    summary();
    $finish;
  end
endmodule